// File: doc/BRIEF.md
# Logical sector to NAND location mapper

This block converts the number of a 512-byte logical sector into the place where that sector lives in a multi-bank NAND array. The result has three parts: the bank, the page (row) address inside that bank, and the byte column inside the page. The logical space is cut into segments. Each segment spans four erase blocks. Two of those blocks sit side by side in one plane, and two more sit at the same position in the second plane. The pages of a segment are spread across these four blocks in turn.

Each request runs in a fixed order. First a segment table RAM is read. Then a short list of write-cache records is walked, one record per clock. Any record can redirect a single page of a logical segment to a page of another physical segment. Chip geometry reaches the block as base-two logarithms on configuration inputs. The segment table and the cache records are filled through plain write ports by whatever logic scans the array. A request is accepted only while the block is idle. The answer appears together with a one-cycle done pulse, and an error flag is raised for sectors that have no mapping.

Top module: `sector_locator`

## Requirements
- R1: With S = 2^cfg_spp_lg sectors per page and P = 2^cfg_ppb_lg pages per block, a sector n belongs to logical segment n / (4·S·P). Its page index inside the segment is (n mod 4·S·P) / S, and its sector slot inside the page is n mod S.
- R2: The row address starts at physical segment × P × 2 and then adds page index / 4.
- R3: When bit 0 of the page index is 1, the row address also gains P, because the page lies in the neighbouring block.
- R4: When bit 1 of the page index is 1, the row address also gains (2^cfg_bpb_lg / 2) × P, because the page lies in the second plane.
- R5: The column equals the sector slot × 528, which covers 512 data bytes and 16 spare bytes for each slot.
- R6: Cache records are examined in rising index order. The first record whose logical segment equals the request's segment, and whose map entry for the page index is valid, supplies the bank, the physical segment and a replacement page index. The row is then formed from those values.
- R7: Records whose index is at or above cfg_used take no part in the search, even when they match.
- R8: If no cache record hits and the table entry is unwritten, marked invalid, or beyond the table depth, err is 1 in the done cycle. A cache hit on such a segment produces no error.
- R9: done is high for exactly one cycle. It arrives 3 + k clock edges after the accepting edge. Here k is the index of the record that hit, or cfg_used when no record hits.
- R10: busy is high from the edge that accepts a request until the edge that raises done. A req seen while busy is ignored and yields neither a result nor an extra done.
- R11: After reset, busy, done and err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_spp_lg | input | SPP_LG_W | log2 of sectors per page |
| cfg_ppb_lg | input | PPB_LG_W | log2 of pages per block |
| cfg_bpb_lg | input | BPB_LG_W | log2 of blocks per bank (at least 1) |
| cfg_used | input | IDX_W | Number of cache records taking part in the search |
| tbl_we | input | 1 | Segment table write strobe |
| tbl_addr | input | LSEG_W | Logical segment to write |
| tbl_valid | input | 1 | Entry holds a mapping (0 = unmapped) |
| tbl_bank | input | BANK_W | Bank of the mapped segment |
| tbl_pseg | input | PSEG_W | Physical segment inside that bank |
| rec_we | input | 1 | Cache record header write strobe |
| rec_idx | input | RIDX_W | Record being written |
| rec_bank | input | BANK_W | Bank of the record |
| rec_pseg | input | PSEG_W | Physical segment of the record |
| rec_lseg | input | LSEG_W | Logical segment the record covers |
| map_we | input | 1 | Page map entry write strobe |
| map_rec | input | RIDX_W | Record whose map is written |
| map_slot | input | PIS_W | Page index inside the logical segment |
| map_valid | input | 1 | Slot is redirected (0 = not cached) |
| map_page | input | PIS_W | Replacement page index inside the record's segment |
| req | input | 1 | Start a lookup (taken only when not busy) |
| req_sector | input | SECTOR_W | Logical sector number |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | No mapping found (valid with done) |
| out_bank | output | BANK_W | Resulting bank |
| out_row | output | ROW_W | Resulting page address within the bank |
| out_col | output | COL_W | Resulting byte column within the page |

## Verification
The checker assumes the geometry inputs and cfg_used stay fixed while busy is high. It also assumes cfg_used never exceeds the record count, cfg_bpb_lg is at least 1, and no table or cache write lands during a lookup. The bench respects all of this: it loads every table entry and cache record while the block is idle, and it changes cfg_used or the geometry only between completed lookups. With those inputs held, the checker relates done, err, busy and the column to each other across cycles. Rows, banks and latencies are compared against values worked out by hand from the geometry formulas.

// File: rtl/sxl_pkg.sv
`timescale 1ns/1ps
package sxl_pkg;
   // controller states of one lookup
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOOK = 2'd1,
      ST_SCAN = 2'd2,
      ST_FIN  = 2'd3
   } sxl_state_e;

   // byte stride of one sector slot: data plus spare area
   localparam int SXL_DATA_BYTES  = 512;
   localparam int SXL_SPARE_BYTES = 16;
   localparam int SXL_SLOT_BYTES  = SXL_DATA_BYTES + SXL_SPARE_BYTES;
   // a segment is four erase blocks
   localparam int SXL_SEG_BLK_LG  = 2;
endpackage

// File: rtl/sxl_split.sv
`timescale 1ns/1ps
module sxl_split #(
   parameter int SECTOR_W = 24,
   parameter int SPP_LG_W = 2,
   parameter int PPB_LG_W = 3,
   parameter int PIS_W    = 6,
   parameter int SIP_W    = 3
) (
   input  logic [SECTOR_W-1:0] sector,
   input  logic [SPP_LG_W-1:0] spp_lg,
   input  logic [PPB_LG_W-1:0] ppb_lg,
   output logic [SECTOR_W-1:0] log_seg,
   output logic [PIS_W-1:0]    pis,
   output logic [SIP_W-1:0]    sip
);
   import sxl_pkg::*;

   logic [7:0]          seg_sh;
   logic [SECTOR_W-1:0] seg_mask;
   logic [SECTOR_W-1:0] page_mask;
   logic [SECTOR_W-1:0] in_seg;
   logic [SECTOR_W-1:0] page_full;
   logic [SECTOR_W-1:0] slot_full;

   always_comb begin
      seg_sh    = 8'(spp_lg) + 8'(ppb_lg) + 8'(SXL_SEG_BLK_LG);
      seg_mask  = ~({SECTOR_W{1'b1}} << seg_sh);
      page_mask = ~({SECTOR_W{1'b1}} << spp_lg);
      log_seg   = sector >> seg_sh;
      in_seg    = sector & seg_mask;
      page_full = in_seg >> spp_lg;
      slot_full = in_seg & page_mask;
      pis       = page_full[PIS_W-1:0];
      sip       = slot_full[SIP_W-1:0];
   end
endmodule

// File: rtl/sxl_seg_table.sv
`timescale 1ns/1ps
module sxl_seg_table #(
   parameter int LSEG_W = 6,
   parameter int BANK_W = 2,
   parameter int PSEG_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [LSEG_W-1:0] wr_addr,
   input  logic              wr_valid,
   input  logic [BANK_W-1:0] wr_bank,
   input  logic [PSEG_W-1:0] wr_pseg,
   input  logic              rd_en,
   input  logic [LSEG_W-1:0] rd_addr,
   output logic              rd_valid,
   output logic [BANK_W-1:0] rd_bank,
   output logic [PSEG_W-1:0] rd_pseg
);
   localparam int DEPTH = 1 << LSEG_W;

   logic              vld_q  [DEPTH];
   logic [BANK_W-1:0] bank_q [DEPTH];
   logic [PSEG_W-1:0] pseg_q [DEPTH];

   // only the valid bits need a reset value
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) vld_q[e] <= 1'b0;
      end else if (wr_en) begin
         vld_q[wr_addr] <= wr_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         bank_q[wr_addr] <= wr_bank;
         pseg_q[wr_addr] <= wr_pseg;
      end
   end

   // registered read port
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_bank  <= '0;
         rd_pseg  <= '0;
      end else if (rd_en) begin
         rd_valid <= vld_q[rd_addr];
         rd_bank  <= bank_q[rd_addr];
         rd_pseg  <= pseg_q[rd_addr];
      end
   end
endmodule

// File: rtl/sxl_cache_set.sv
`timescale 1ns/1ps
module sxl_cache_set #(
   parameter int NCACHE = 8,
   parameter int RIDX_W = 3,
   parameter int IDX_W  = 4,
   parameter int BANK_W = 2,
   parameter int PSEG_W = 11,
   parameter int LSEG_W = 6,
   parameter int SEG_W  = 24,
   parameter int PIS_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rec_we,
   input  logic [RIDX_W-1:0] rec_idx,
   input  logic [BANK_W-1:0] rec_bank,
   input  logic [PSEG_W-1:0] rec_pseg,
   input  logic [LSEG_W-1:0] rec_lseg,
   input  logic              map_we,
   input  logic [RIDX_W-1:0] map_rec,
   input  logic [PIS_W-1:0]  map_slot,
   input  logic              map_valid,
   input  logic [PIS_W-1:0]  map_page,
   input  logic [SEG_W-1:0]  look_seg,
   input  logic [PIS_W-1:0]  look_pis,
   input  logic [IDX_W-1:0]  look_idx,
   output logic              look_hit,
   output logic [BANK_W-1:0] look_bank,
   output logic [PSEG_W-1:0] look_pseg,
   output logic [PIS_W-1:0]  look_page
);
   localparam int MAPD = 1 << PIS_W;

   logic [NCACHE-1:0] hit_vec;
   logic [BANK_W-1:0] bank_vec [NCACHE];
   logic [PSEG_W-1:0] pseg_vec [NCACHE];
   logic [PIS_W-1:0]  page_vec [NCACHE];

   for (genvar r = 0; r < NCACHE; r++) begin : g_rec
      logic [BANK_W-1:0] bank_q;
      logic [PSEG_W-1:0] pseg_q;
      logic [LSEG_W-1:0] lseg_q;
      logic              mv_q [MAPD];
      logic [PIS_W-1:0]  mp_q [MAPD];
      logic              sel_hdr;
      logic              sel_map;

      assign sel_hdr = rec_we && (rec_idx == RIDX_W'(r));
      assign sel_map = map_we && (map_rec == RIDX_W'(r));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bank_q <= '0;
            pseg_q <= '0;
            lseg_q <= '0;
            for (int s = 0; s < MAPD; s++) mv_q[s] <= 1'b0;
         end else begin
            if (sel_hdr) begin
               bank_q <= rec_bank;
               pseg_q <= rec_pseg;
               lseg_q <= rec_lseg;
            end
            if (sel_map) mv_q[map_slot] <= map_valid;
         end
      end

      always_ff @(posedge clk) begin
         if (sel_map) mp_q[map_slot] <= map_page;
      end

      assign hit_vec[r]  = (SEG_W'(lseg_q) == look_seg) && mv_q[look_pis];
      assign bank_vec[r] = bank_q;
      assign pseg_vec[r] = pseg_q;
      assign page_vec[r] = mp_q[look_pis];
   end

   // pick the record addressed by the scan index
   always_comb begin
      look_hit  = 1'b0;
      look_bank = '0;
      look_pseg = '0;
      look_page = '0;
      for (int r = 0; r < NCACHE; r++) begin
         if (look_idx == IDX_W'(r)) begin
            look_hit  = hit_vec[r];
            look_bank = bank_vec[r];
            look_pseg = pseg_vec[r];
            look_page = page_vec[r];
         end
      end
   end
endmodule

// File: rtl/sxl_row_calc.sv
`timescale 1ns/1ps
module sxl_row_calc #(
   parameter int PSEG_W   = 11,
   parameter int PIS_W    = 6,
   parameter int SIP_W    = 3,
   parameter int ROW_W    = 17,
   parameter int COL_W    = 13,
   parameter int PPB_LG_W = 3,
   parameter int BPB_LG_W = 4
) (
   input  logic [PSEG_W-1:0]   pseg,
   input  logic [PIS_W-1:0]    pis,
   input  logic [SIP_W-1:0]    sip,
   input  logic [PPB_LG_W-1:0] ppb_lg,
   input  logic [BPB_LG_W-1:0] bpb_lg,
   output logic [ROW_W-1:0]    row,
   output logic [COL_W-1:0]    col
);
   import sxl_pkg::*;

   logic [7:0]       seg_sh;
   logic [7:0]       plane_sh;
   logic [ROW_W-1:0] base;
   logic [ROW_W-1:0] blk_off;
   logic [ROW_W-1:0] plane_off;
   logic [ROW_W-1:0] depth_off;
   logic [COL_W-1:0] slot_c;

   always_comb begin
      // segment start: two blocks' worth of pages per segment within a plane
      seg_sh    = 8'(ppb_lg) + 8'd1;
      plane_sh  = 8'(bpb_lg) + 8'(ppb_lg) - 8'd1;
      base      = ROW_W'(pseg) << seg_sh;
      blk_off   = pis[0] ? (ROW_W'(1) << ppb_lg) : '0;
      plane_off = pis[1] ? (ROW_W'(1) << plane_sh) : '0;
      depth_off = ROW_W'(pis >> SXL_SEG_BLK_LG);
      row       = base + blk_off + plane_off + depth_off;
      // slot stride of 528 bytes written as 512 + 16
      slot_c    = COL_W'(sip);
      col       = (slot_c << 9) + (slot_c << 4);
   end
endmodule

// File: rtl/sector_locator.sv
`timescale 1ns/1ps
module sector_locator #(
   parameter int SECTOR_W   = 24,
   parameter int BANK_W     = 2,
   parameter int LSEG_W     = 6,
   parameter int BLK_LG_MAX = 13,
   parameter int PPB_LG_MAX = 4,
   parameter int SPP_LG_MAX = 3,
   parameter int NCACHE     = 8,
   localparam int PSEG_W    = BLK_LG_MAX - 2,
   localparam int PIS_W     = PPB_LG_MAX + 2,
   localparam int SIP_W     = SPP_LG_MAX,
   localparam int ROW_W     = BLK_LG_MAX + PPB_LG_MAX,
   localparam int COL_W     = $clog2(528 << SPP_LG_MAX),
   localparam int IDX_W     = $clog2(NCACHE + 1),
   localparam int RIDX_W    = $clog2(NCACHE),
   localparam int SPP_LG_W  = $clog2(SPP_LG_MAX + 1),
   localparam int PPB_LG_W  = $clog2(PPB_LG_MAX + 1),
   localparam int BPB_LG_W  = $clog2(BLK_LG_MAX + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SPP_LG_W-1:0] cfg_spp_lg,
   input  logic [PPB_LG_W-1:0] cfg_ppb_lg,
   input  logic [BPB_LG_W-1:0] cfg_bpb_lg,
   input  logic [IDX_W-1:0]    cfg_used,
   input  logic                tbl_we,
   input  logic [LSEG_W-1:0]   tbl_addr,
   input  logic                tbl_valid,
   input  logic [BANK_W-1:0]   tbl_bank,
   input  logic [PSEG_W-1:0]   tbl_pseg,
   input  logic                rec_we,
   input  logic [RIDX_W-1:0]   rec_idx,
   input  logic [BANK_W-1:0]   rec_bank,
   input  logic [PSEG_W-1:0]   rec_pseg,
   input  logic [LSEG_W-1:0]   rec_lseg,
   input  logic                map_we,
   input  logic [RIDX_W-1:0]   map_rec,
   input  logic [PIS_W-1:0]    map_slot,
   input  logic                map_valid,
   input  logic [PIS_W-1:0]    map_page,
   input  logic                req,
   input  logic [SECTOR_W-1:0] req_sector,
   output logic                busy,
   output logic                done,
   output logic                err,
   output logic [BANK_W-1:0]   out_bank,
   output logic [ROW_W-1:0]    out_row,
   output logic [COL_W-1:0]    out_col
);
   import sxl_pkg::*;

   // elaboration-time parameter checks
   if (NCACHE < 2) begin : g_bad_ncache
      initial $fatal(1, "sector_locator: NCACHE must be at least 2");
   end
   if (SPP_LG_MAX < 1) begin : g_bad_spp
      initial $fatal(1, "sector_locator: SPP_LG_MAX must be at least 1");
   end
   if (BLK_LG_MAX < 3) begin : g_bad_blk
      initial $fatal(1, "sector_locator: BLK_LG_MAX must be at least 3");
   end
   if (LSEG_W > SECTOR_W) begin : g_bad_lseg
      initial $fatal(1, "sector_locator: LSEG_W wider than SECTOR_W");
   end

   sxl_state_e          state_q;
   logic [SECTOR_W-1:0] sector_q;
   logic [IDX_W-1:0]    idx_q;
   logic                hit_q;
   logic [BANK_W-1:0]   c_bank_q;
   logic [PSEG_W-1:0]   c_pseg_q;
   logic [PIS_W-1:0]    c_page_q;
   logic                done_q;
   logic                err_q;
   logic [BANK_W-1:0]   bank_q;
   logic [ROW_W-1:0]    row_q;
   logic [COL_W-1:0]    col_q;

   logic [SECTOR_W-1:0] log_seg;
   logic [PIS_W-1:0]    pis;
   logic [SIP_W-1:0]    sip;
   logic                in_range;
   logic                t_valid;
   logic [BANK_W-1:0]   t_bank;
   logic [PSEG_W-1:0]   t_pseg;
   logic                c_hit;
   logic [BANK_W-1:0]   c_bank;
   logic [PSEG_W-1:0]   c_pseg;
   logic [PIS_W-1:0]    c_page;
   logic [BANK_W-1:0]   sel_bank;
   logic [PSEG_W-1:0]   sel_pseg;
   logic [PIS_W-1:0]    sel_page;
   logic [ROW_W-1:0]    calc_row;
   logic [COL_W-1:0]    calc_col;
   logic                scan_end;

   sxl_split #(
      .SECTOR_W (SECTOR_W),
      .SPP_LG_W (SPP_LG_W),
      .PPB_LG_W (PPB_LG_W),
      .PIS_W    (PIS_W),
      .SIP_W    (SIP_W)
   ) u_split (
      .sector  (sector_q),
      .spp_lg  (cfg_spp_lg),
      .ppb_lg  (cfg_ppb_lg),
      .log_seg (log_seg),
      .pis     (pis),
      .sip     (sip)
   );

   assign in_range = ((log_seg >> LSEG_W) == '0);

   sxl_seg_table #(
      .LSEG_W (LSEG_W),
      .BANK_W (BANK_W),
      .PSEG_W (PSEG_W)
   ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (tbl_we),
      .wr_addr  (tbl_addr),
      .wr_valid (tbl_valid),
      .wr_bank  (tbl_bank),
      .wr_pseg  (tbl_pseg),
      .rd_en    (state_q == ST_LOOK),
      .rd_addr  (log_seg[LSEG_W-1:0]),
      .rd_valid (t_valid),
      .rd_bank  (t_bank),
      .rd_pseg  (t_pseg)
   );

   sxl_cache_set #(
      .NCACHE (NCACHE),
      .RIDX_W (RIDX_W),
      .IDX_W  (IDX_W),
      .BANK_W (BANK_W),
      .PSEG_W (PSEG_W),
      .LSEG_W (LSEG_W),
      .SEG_W  (SECTOR_W),
      .PIS_W  (PIS_W)
   ) u_cache (
      .clk       (clk),
      .rst_n     (rst_n),
      .rec_we    (rec_we),
      .rec_idx   (rec_idx),
      .rec_bank  (rec_bank),
      .rec_pseg  (rec_pseg),
      .rec_lseg  (rec_lseg),
      .map_we    (map_we),
      .map_rec   (map_rec),
      .map_slot  (map_slot),
      .map_valid (map_valid),
      .map_page  (map_page),
      .look_seg  (log_seg),
      .look_pis  (pis),
      .look_idx  (idx_q),
      .look_hit  (c_hit),
      .look_bank (c_bank),
      .look_pseg (c_pseg),
      .look_page (c_page)
   );

   // cached location wins over the table entry
   assign sel_bank = hit_q ? c_bank_q : t_bank;
   assign sel_pseg = hit_q ? c_pseg_q : t_pseg;
   assign sel_page = hit_q ? c_page_q : pis;

   sxl_row_calc #(
      .PSEG_W   (PSEG_W),
      .PIS_W    (PIS_W),
      .SIP_W    (SIP_W),
      .ROW_W    (ROW_W),
      .COL_W    (COL_W),
      .PPB_LG_W (PPB_LG_W),
      .BPB_LG_W (BPB_LG_W)
   ) u_calc (
      .pseg   (sel_pseg),
      .pis    (sel_page),
      .sip    (sip),
      .ppb_lg (cfg_ppb_lg),
      .bpb_lg (cfg_bpb_lg),
      .row    (calc_row),
      .col    (calc_col)
   );

   assign scan_end = (idx_q >= cfg_used) || (idx_q >= IDX_W'(NCACHE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         sector_q <= '0;
         idx_q    <= '0;
         hit_q    <= 1'b0;
         c_bank_q <= '0;
         c_pseg_q <= '0;
         c_page_q <= '0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         bank_q   <= '0;
         row_q    <= '0;
         col_q    <= '0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req) begin
                  sector_q <= req_sector;
                  idx_q    <= '0;
                  hit_q    <= 1'b0;
                  state_q  <= ST_LOOK;
               end
            end
            ST_LOOK: state_q <= ST_SCAN;
            ST_SCAN: begin
               if (scan_end) begin
                  state_q <= ST_FIN;
               end else if (c_hit) begin
                  hit_q    <= 1'b1;
                  c_bank_q <= c_bank;
                  c_pseg_q <= c_pseg;
                  c_page_q <= c_page;
                  state_q  <= ST_FIN;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            ST_FIN: begin
               done_q  <= 1'b1;
               err_q   <= !hit_q && (!t_valid || !in_range);
               bank_q  <= sel_bank;
               row_q   <= calc_row;
               col_q   <= calc_col;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign done     = done_q;
   assign err      = err_q;
   assign out_bank = bank_q;
   assign out_row  = row_q;
   assign out_col  = col_q;
endmodule

// File: rtl/sector_locator_chk.sv
`timescale 1ns/1ps
module sector_locator_chk #(
   parameter int COL_W    = 13,
   parameter int SPP_LG_W = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req,
   input logic                busy,
   input logic                done,
   input logic                err,
   input logic [COL_W-1:0]    out_col,
   input logic [SPP_LG_W-1:0] cfg_spp_lg
);
   // R9: the result strobe never lasts two cycles
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: an idle request is taken on the next edge
   a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !busy) |=> busy);

   // R10: the block is idle whenever done is shown
   a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R10: busy only ends together with a result
   a_r10_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R8: the error flag only accompanies a result
   a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

   // R5: column sits on a slot boundary inside the page
   a_r5_col_slot: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((32'(out_col) % 528) == 0 && 32'(out_col) < (528 << cfg_spp_lg)));
endmodule

bind sector_locator sector_locator_chk #(
   .COL_W    (COL_W),
   .SPP_LG_W (SPP_LG_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req        (req),
   .busy       (busy),
   .done       (done),
   .err        (err),
   .out_col    (out_col),
   .cfg_spp_lg (cfg_spp_lg)
);

// File: tb/sim_sector_locator.sv
`timescale 1ns/1ps
module sim_sector_locator;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_spp_lg = 2'd2;
   logic [2:0]  cfg_ppb_lg = 3'd4;
   logic [3:0]  cfg_bpb_lg = 4'd13;
   logic [3:0]  cfg_used = 4'd2;
   logic        tbl_we = 1'b0;
   logic [5:0]  tbl_addr = '0;
   logic        tbl_valid = 1'b0;
   logic [1:0]  tbl_bank = '0;
   logic [10:0] tbl_pseg = '0;
   logic        rec_we = 1'b0;
   logic [2:0]  rec_idx = '0;
   logic [1:0]  rec_bank = '0;
   logic [10:0] rec_pseg = '0;
   logic [5:0]  rec_lseg = '0;
   logic        map_we = 1'b0;
   logic [2:0]  map_rec = '0;
   logic [5:0]  map_slot = '0;
   logic        map_valid = 1'b0;
   logic [5:0]  map_page = '0;
   logic        req = 1'b0;
   logic [23:0] req_sector = '0;
   logic        busy, done, err;
   logic [1:0]  out_bank;
   logic [16:0] out_row;
   logic [12:0] out_col;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   sector_locator u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_spp_lg(cfg_spp_lg), .cfg_ppb_lg(cfg_ppb_lg), .cfg_bpb_lg(cfg_bpb_lg),
      .cfg_used(cfg_used),
      .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_valid(tbl_valid),
      .tbl_bank(tbl_bank), .tbl_pseg(tbl_pseg),
      .rec_we(rec_we), .rec_idx(rec_idx), .rec_bank(rec_bank),
      .rec_pseg(rec_pseg), .rec_lseg(rec_lseg),
      .map_we(map_we), .map_rec(map_rec), .map_slot(map_slot),
      .map_valid(map_valid), .map_page(map_page),
      .req(req), .req_sector(req_sector),
      .busy(busy), .done(done), .err(err),
      .out_bank(out_bank), .out_row(out_row), .out_col(out_col)
   );

   // geometry: 4 sectors/page, 16 pages/block, 8192 blocks; 256 sectors/segment
   localparam int NV = 14;
   localparam int V_SEC  [NV] = '{0, 7, 10, 13, 255, 284, 297, 513, 516, 1023, 1280, 1024, 16384, 12};
   localparam int V_BANK [NV] = '{1, 1, 1, 1, 1, 0, 2, 3, 0, 3, 0, 0, 0, 1};
   localparam int V_ROW  [NV] = '{160, 176, 65696, 65712, 65727, 9618, 68738, 12816, 0, 131071, 0, 0, 0, 65712};
   localparam int V_COL  [NV] = '{0, 1584, 1056, 528, 1584, 0, 528, 528, 0, 1584, 0, 0, 0, 0};
   localparam int V_ERR  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1, 1, 0};
   localparam int V_LAT  [NV] = '{5, 5, 5, 5, 5, 3, 5, 4, 5, 5, 5, 5, 5, 5};

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
         summary();
      end
   end

   task automatic tbl_put(input int a, input int v, input int b, input int p);
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = 6'(a); tbl_valid = v[0];
      tbl_bank = 2'(b); tbl_pseg = 11'(p);
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic rec_put(input int i, input int b, input int p, input int l);
      @(negedge clk);
      rec_we = 1'b1; rec_idx = 3'(i); rec_bank = 2'(b);
      rec_pseg = 11'(p); rec_lseg = 6'(l);
      @(negedge clk);
      rec_we = 1'b0;
   endtask

   task automatic map_put(input int i, input int s, input int pg);
      @(negedge clk);
      map_we = 1'b1; map_rec = 3'(i); map_slot = 6'(s);
      map_valid = 1'b1; map_page = 6'(pg);
      @(negedge clk);
      map_we = 1'b0;
   endtask

   // issue one lookup and count edges from acceptance to done
   task automatic run(input int sec, output int b, output int r, output int c,
                      output int e, output int lat);
      int n;
      @(negedge clk);
      req = 1'b1; req_sector = 24'(sec);
      @(posedge clk);
      n = 0;
      forever begin
         @(negedge clk);
         req = 1'b0;
         if (done) break;
         n++;
         if (n > 40) break;
      end
      b = out_bank; r = out_row; c = out_col; e = err; lat = n;
   endtask

   task automatic lookup(input string tag, input int sec, input int xb, input int xr,
                         input int xc, input int xe, input int xl);
      int b, r, c, e, l;
      run(sec, b, r, c, e, l);
      check({tag, " err"}, e, xe);
      check({tag, " latency"}, l, xl);
      if (xe == 0) begin
         check({tag, " bank"}, b, xb);
         check({tag, " row"}, r, xr);
         check({tag, " col"}, c, xc);
      end
   endtask

   initial begin
      int dn;
      repeat (3) @(negedge clk);
      // R11: reset state
      check("R11 busy", busy, 0);
      check("R11 done", done, 0);
      check("R11 err", err, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 busy after release", busy, 0);

      tbl_put(0, 1, 1, 5);
      tbl_put(1, 1, 2, 100);
      tbl_put(2, 0, 0, 0);
      tbl_put(3, 1, 3, 2047);
      tbl_put(5, 1, 0, 0);
      rec_put(0, 0, 300, 1);  map_put(0, 7, 9);
      rec_put(1, 3, 400, 2);  map_put(1, 0, 1);
      rec_put(2, 2, 500, 0);  map_put(2, 3, 4);
      rec_put(3, 1, 7, 1);    map_put(3, 7, 12); map_put(3, 10, 2);

      // R1..R8 vector walk with two records in use
      for (int i = 0; i < NV; i++) begin
         string t;
         t = $sformatf("R1-R8 vec%0d", i);
         lookup({t, " R1 R2 R3 R4 R5 R6 R7 R8 R9"}, V_SEC[i], V_BANK[i], V_ROW[i],
                V_COL[i], V_ERR[i], V_LAT[i]);
      end

      // R6: with four records, index 0 still wins for page 7 of segment 1
      @(negedge clk); cfg_used = 4'd4;
      lookup("R6 first match", 284, 0, 9618, 0, 0, 3);
      // R6: record 3 supplies page 10 of segment 1 (record 0 slot invalid)
      lookup("R6 later record", 297, 1, 65760, 528, 0, 6);
      // R7: record 2 now in use, redirects page 3 of segment 0
      lookup("R7 record enabled", 12, 2, 16001, 0, 0, 5);
      // R8: cache hit on an invalid table entry gives no error
      lookup("R8 hit on unmapped", 513, 3, 12816, 528, 0, 4);

      // R7: no records in use, table wins
      @(negedge clk); cfg_used = 4'd0;
      lookup("R7 none used", 284, 2, 68753, 0, 0, 3);

      // R1 R4: other geometry, 8 sectors/page, 4 pages/block, 1024 blocks
      @(negedge clk);
      cfg_spp_lg = 2'd3; cfg_ppb_lg = 3'd2; cfg_bpb_lg = 4'd10;
      lookup("R1 R4 geometry2", 181, 2, 2849, 2640, 0, 3);
      @(negedge clk);
      cfg_spp_lg = 2'd2; cfg_ppb_lg = 3'd4; cfg_bpb_lg = 4'd13;

      // R10: request during busy is ignored
      @(negedge clk);
      req = 1'b1; req_sector = 24'd0;
      @(negedge clk);
      req_sector = 24'd7;
      check("R10 busy after accept", busy, 1);
      dn = 0;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (k == 1) req = 1'b0;
         if (done) begin
            dn++;
            check("R10 first request row", out_row, 160);
            check("R10 first request col", out_col, 0);
         end
      end
      req = 1'b0;
      check("R10 R9 single done", dn, 1);
      check("R10 idle at end", busy, 0);

      summary();
   end
endmodule